// File: doc/BRIEF.md
# Tear-Triggered Frame Transfer and Interrupt Controller

This block decides when a display frame transfer begins and keeps the interrupt state for that transfer. In software-start mode a one-cycle start pulse launches the transfer. In tear mode the panel's tear-effect line is sampled through a synchronizer, and the first active edge seen while idle launches the transfer. The active edge is either rising or falling, selected by a configuration input. The serial and parallel interface engines are outside the block. They appear only as a strobe that marks each byte accepted by the panel side, and this strobe is counted against a programmed byte total.

During a transfer the block also watches the level of the 128-entry, 32-bit pixel FIFO. It records four things: the level dropping to or below a threshold, the FIFO running dry, a push into a full FIFO while sending, and a push into a full FIFO while receiving. Seven events each hold a sticky status bit. Software clears a status bit by writing 1 to it, and a mask decides which status bits reach the single interrupt line.

Top module: `frame_kick_irq_ctrl`

## Requirements
- R1: After reset, `busy`, every bit of `irq_status` and `irq` are 0.
- R2: With `cfg_tear_en`=0, a `sw_start` pulse seen while idle sets `busy` after the next clock edge. Tear edges then neither start a transfer nor set status bit 1.
- R3: With `cfg_tear_en`=1, `sw_start` is ignored. An active edge on `te_in` (rising when `cfg_tear_pol`=1, falling when 0) starts the transfer, and `busy` rises on the third clock edge after `te_in` changes: two synchronizer stages plus one decision stage.
- R4: Status bit 1 (tear) sets on every detected active edge while tear mode is on. This includes edges that arrive while `busy` is high, and those edges do not restart the transfer.
- R5: `byte_acc` is counted only while `busy` is high. The clock edge that accepts byte number `cfg_total` clears `busy` and sets status bit 2 (transfer done).
- R6: Status bit 0 (waveform finish) sets together with bit 2 only when the transfer was started by `sw_start`. It never sets for a tear-started transfer.
- R7: While `busy` is high and `dir_rx`=0, status bit 6 sets on every clock edge where `fifo_level` <= `cfg_thresh`.
- R8: While `busy` is high and `dir_rx`=0, status bit 4 sets on every clock edge where `fifo_level` is 0.
- R9: While `busy` is high, a `fifo_push` with `fifo_level` equal to 128 sets status bit 5 when `dir_rx`=0 and status bit 3 when `dir_rx`=1.
- R10: Status bits are sticky. A 1 in `irq_clr` clears the matching bit on the next edge, unless the event occurs in that same cycle, in which case the event wins.
- R11: `irq` is high exactly when some status bit and its `irq_mask` bit are both 1.
- R12: A transfer whose bytes stop before `cfg_total` keeps `busy` high indefinitely and raises neither bit 0 nor bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tear_en | input | 1 | 1: tear edge starts transfers; 0: `sw_start` does |
| cfg_tear_pol | input | 1 | Active tear edge: 1 rising, 0 falling |
| te_in | input | 1 | Asynchronous tear-effect line from the panel |
| sw_start | input | 1 | Software start pulse |
| cfg_total | input | 16 | Bytes per transfer (must be nonzero) |
| byte_acc | input | 1 | Interface engine accepted one byte |
| dir_rx | input | 1 | 1 while the transfer is a read |
| fifo_level | input | 8 | Current FIFO fill level, 0 to 128 |
| cfg_thresh | input | 8 | Low-water threshold for status bit 6 |
| fifo_push | input | 1 | A FIFO write is attempted this cycle |
| irq_mask | input | 7 | Per-bit interrupt enable |
| irq_clr | input | 7 | Write-1-to-clear strobe per status bit |
| busy | output | 1 | Transfer in progress |
| irq_status | output | 7 | Raw status: 0 finish, 1 tear, 2 done, 3 rx overflow, 4 tx empty, 5 tx overflow, 6 tx threshold |
| irq | output | 1 | Combined masked interrupt |

## Verification
The start path is driven with software pulses and with tear pulses of both polarities, in both modes. This separates a start decision taken from the wrong source from one taken on the wrong edge, and shows whether the synchronizer latency holds. Byte streams with gaps, a long starvation and an exact final byte show whether the count ends the transfer on the right edge and whether the finish event follows the start origin. FIFO levels at 0, at the threshold, above it and at full, in both directions, show which event each level produces. Clears that collide with live events check the set-over-clear rule.

// File: rtl/fk_pkg.sv
package fk_pkg;
   localparam int IRQ_N     = 7;
   localparam int B_FIN     = 0;
   localparam int B_TEAR    = 1;
   localparam int B_DONE    = 2;
   localparam int B_RXOVF   = 3;
   localparam int B_TXEMPTY = 4;
   localparam int B_TXOVF   = 5;
   localparam int B_TXTHR   = 6;
endpackage

// File: rtl/te_edge_sync.sv
module te_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic te_in,
   input  logic pol_rise,
   output logic edge_hit
);
   logic [STAGES-1:0] sh;
   logic              prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("te_edge_sync needs at least two synchronizer stages");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= te_in;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sh[STAGES-1];
   end

   // Edge is taken between the settled stage and its one-cycle-old copy.
   assign edge_hit = pol_rise ? (sh[STAGES-1] & ~prev) : (~sh[STAGES-1] & prev);
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tear_en,
   input  logic             te_edge,
   input  logic             sw_start,
   input  logic             byte_acc,
   input  logic [CNT_W-1:0] total,
   output logic             busy,
   output logic             by_te,
   output logic             done_ev,
   output logic             fin_ev
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_next;
   logic             start, last;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("xfer_seq counter width must be positive");
   end

   assign start    = !busy && (tear_en ? te_edge : sw_start);
   assign cnt_next = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
   assign last     = busy && byte_acc && (cnt_next >= {1'b0, total});
   assign done_ev  = last;
   assign fin_ev   = last && !by_te;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         by_te <= 1'b0;
         cnt   <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         by_te <= tear_en;
         cnt   <= '0;
      end else if (last) begin
         busy  <= 1'b0;
         cnt   <= '0;
      end else if (busy && byte_acc) begin
         cnt   <= cnt_next[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/fifo_event_mon.sv
module fifo_event_mon #(
   parameter int DEPTH = 128,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             busy,
   input  logic             dir_rx,
   input  logic             push,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] thresh,
   output logic             tx_empty,
   output logic             tx_thr,
   output logic             tx_ovf,
   output logic             rx_ovf
);
   localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
   logic at_full;

   if (DEPTH < 2) begin : g_bad_depth
      $error("fifo_event_mon depth must be at least 2");
   end

   assign at_full  = (level == FULL);
   assign tx_empty = busy && !dir_rx && (level == '0);
   assign tx_thr   = busy && !dir_rx && (level <= thresh);
   assign tx_ovf   = busy && !dir_rx && push && at_full;
   assign rx_ovf   = busy &&  dir_rx && push && at_full;
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] mask,
   output logic [N-1:0] status,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      status[i] <= 1'b0;
         else if (set[i]) status[i] <= 1'b1;
         else if (clr[i]) status[i] <= 1'b0;
      end
   end
   assign irq = |(status & mask);
endmodule

// File: rtl/frame_kick_irq_ctrl.sv
module frame_kick_irq_ctrl
   import fk_pkg::*;
#(
   parameter int FIFO_DEPTH  = 128,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_tear_en,
   input  logic             cfg_tear_pol,
   input  logic             te_in,
   input  logic             sw_start,
   input  logic [CNT_W-1:0] cfg_total,
   input  logic             byte_acc,
   input  logic             dir_rx,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [LVL_W-1:0] cfg_thresh,
   input  logic             fifo_push,
   input  logic [IRQ_N-1:0] irq_mask,
   input  logic [IRQ_N-1:0] irq_clr,
   output logic             busy,
   output logic [IRQ_N-1:0] irq_status,
   output logic             irq
);
   logic te_edge, by_te, done_ev, fin_ev;
   logic tx_empty, tx_thr, tx_ovf, rx_ovf;
   logic [IRQ_N-1:0] ev_set;

   te_edge_sync #(.STAGES(SYNC_STAGES)) u_te (
      .clk(clk), .rst_n(rst_n), .te_in(te_in),
      .pol_rise(cfg_tear_pol), .edge_hit(te_edge)
   );

   xfer_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .tear_en(cfg_tear_en), .te_edge(te_edge),
      .sw_start(sw_start), .byte_acc(byte_acc), .total(cfg_total),
      .busy(busy), .by_te(by_te), .done_ev(done_ev), .fin_ev(fin_ev)
   );

   fifo_event_mon #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fmon (
      .busy(busy), .dir_rx(dir_rx), .push(fifo_push), .level(fifo_level),
      .thresh(cfg_thresh), .tx_empty(tx_empty), .tx_thr(tx_thr),
      .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
   );

   always_comb begin
      ev_set            = '0;
      ev_set[B_FIN]     = fin_ev;
      ev_set[B_TEAR]    = cfg_tear_en && te_edge;
      ev_set[B_DONE]    = done_ev;
      ev_set[B_RXOVF]   = rx_ovf;
      ev_set[B_TXEMPTY] = tx_empty;
      ev_set[B_TXOVF]   = tx_ovf;
      ev_set[B_TXTHR]   = tx_thr;
   end

   irq_bank #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(irq_clr),
      .mask(irq_mask), .status(irq_status), .irq(irq)
   );
endmodule

// File: rtl/fk_checks.sv
module fk_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       by_te,
   input logic       te_edge,
   input logic       cfg_tear_en,
   input logic       byte_acc,
   input logic [6:0] irq_status,
   input logic [6:0] irq_clr,
   input logic [6:0] irq_mask,
   input logic       irq
);
   assert_tear_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(cfg_tear_en)) |-> $past(te_edge));

   assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[2]) |-> $fell(busy));

   assert_finish_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[0]) |-> (!$past(by_te) && $fell(busy)));

   assert_sticky_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_status[4]) && !$past(irq_clr[4])) |-> irq_status[4]);

   assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (|(irq_status & irq_mask)));

   assert_stall_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !byte_acc) |=> busy);
endmodule

bind frame_kick_irq_ctrl fk_checks u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .by_te(by_te), .te_edge(te_edge),
   .cfg_tear_en(cfg_tear_en), .byte_acc(byte_acc), .irq_status(irq_status),
   .irq_clr(irq_clr), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/sim_frame_kick_irq_ctrl.sv
`timescale 1ns/1ps
module sim_frame_kick_irq_ctrl;
   logic clk = 0, rst_n = 0;
   logic tear_en = 0, tear_pol = 1, te = 0, sw_start = 0, byte_acc = 0;
   logic dir_rx = 0, push = 0;
   logic [15:0] total = 16'd5;
   logic [7:0] level = 8'd10, thresh = 8'd4;
   logic [6:0] mask = 0, clr = 0;
   logic busy, irq;
   logic [6:0] status;

   int checks = 0, bad = 0, cyc = 0;
   bit finished = 0;

   // reference model state
   bit m_busy = 0, m_te = 0, m_s1 = 0, m_s2 = 0, m_pv = 0;
   int m_cnt = 0;
   bit [6:0] m_st = 0;

   always #10 clk = ~clk;

   frame_kick_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_tear_en(tear_en), .cfg_tear_pol(tear_pol),
      .te_in(te), .sw_start(sw_start), .cfg_total(total), .byte_acc(byte_acc),
      .dir_rx(dir_rx), .fifo_level(level), .cfg_thresh(thresh), .fifo_push(push),
      .irq_mask(mask), .irq_clr(clr), .busy(busy), .irq_status(status), .irq(irq)
   );

   function automatic string tag_of(int i);
      case (i)
         0: return "R6";
         1: return "R4";
         2: return "R5";
         3: return "R9";
         4: return "R8";
         5: return "R9";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural model, advanced on each edge from the inputs held since the last negedge
   always @(posedge clk) begin
      bit e;
      bit [6:0] s;
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_te = 0; m_s1 = 0; m_s2 = 0; m_pv = 0; m_cnt = 0; m_st = 0;
      end else begin
         e = tear_pol ? (m_s2 && !m_pv) : (!m_s2 && m_pv);
         s = 0;
         if (tear_en && e) s[1] = 1;
         if (m_busy && !dir_rx && level == 0) s[4] = 1;
         if (m_busy && !dir_rx && level <= thresh) s[6] = 1;
         if (m_busy && push && level == 128) begin
            if (dir_rx) s[3] = 1; else s[5] = 1;
         end
         if (!m_busy) begin
            if (tear_en ? e : sw_start) begin m_busy = 1; m_cnt = 0; m_te = tear_en; end
         end else if (byte_acc) begin
            if (m_cnt + 1 >= int'(total)) begin
               m_busy = 0; m_cnt = 0; s[2] = 1;
               if (!m_te) s[0] = 1;
            end else m_cnt++;
         end
         m_st = (m_st & ~clr) | s;
         m_pv = m_s2; m_s2 = m_s1; m_s1 = te;
      end
   end

   // compare every cycle, 5 ns after the edge
   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         chk("R12", busy, m_busy);
         for (int i = 0; i < 7; i++) chk(tag_of(i), status[i], m_st[i]);
         chk("R11", irq, |(m_st & mask));
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start();
      sw_start = 1; step(1); sw_start = 0;
   endtask

   task automatic clear_all();
      clr = 7'h7f; step(1); clr = 0;
   endtask

   task automatic send_bytes(input int n);
      for (int i = 0; i < n; i++) begin
         byte_acc = 1; step(1); byte_acc = 0; step(1);
      end
   endtask

   initial begin
      step(3);
      chk("R1", busy, 0); chk("R1", status, 0); chk("R1", irq, 0);
      rst_n = 1; step(2);

      // software start; tear pulses are ignored in this mode
      pulse_start(); step(1);
      chk("R2", busy, 1);
      te = 1; step(4); te = 0; step(4);
      chk("R2", status[1], 0);
      send_bytes(4);
      chk("R12", busy, 1);
      chk("R5", status[2], 0);
      send_bytes(1);
      chk("R5", busy, 0); chk("R5", status[2], 1); chk("R6", status[0], 1);
      clear_all(); step(1);
      chk("R10", status, 0);

      // tear mode, rising edge
      tear_en = 1; tear_pol = 1;
      pulse_start(); step(2);
      chk("R3", busy, 0);
      te = 1; step(2);
      chk("R3", busy, 0);
      step(1);
      chk("R3", busy, 1); chk("R4", status[1], 1);
      te = 0; clr = 7'h02; step(1); clr = 0; step(2);
      chk("R10", status[1], 0);
      te = 1; step(4);
      chk("R4", status[1], 1); chk("R4", busy, 1);
      step(50);
      chk("R12", busy, 1); chk("R12", status[2], 0);
      send_bytes(5);
      chk("R5", status[2], 1); chk("R6", status[0], 0);
      clear_all();

      // tear mode, falling edge
      tear_pol = 0; step(3);
      te = 0; step(4);
      chk("R3", busy, 1);
      send_bytes(5); clear_all();

      // FIFO level events in transmit
      tear_en = 0; total = 16'd3; pulse_start();
      level = 8'd5; step(3);
      chk("R7", status[6], 0);
      level = 8'd4; step(2);
      chk("R7", status[6], 1); chk("R8", status[4], 0);
      level = 8'd0; step(2);
      chk("R8", status[4], 1);
      clr = 7'h10; step(1); clr = 0; step(1);
      chk("R10", status[4], 1);
      level = 8'd128; push = 1; step(1); push = 0; step(1);
      chk("R9", status[5], 1); chk("R9", status[3], 0);
      clear_all(); step(1);
      chk("R10", status, 0);
      dir_rx = 1; push = 1; step(1); push = 0; step(1);
      chk("R9", status[3], 1); chk("R9", status[5], 0);
      mask = 7'h08; step(1);
      chk("R11", irq, 1);
      mask = 7'h77; step(1);
      chk("R11", irq, 0);
      send_bytes(3); dir_rx = 0; level = 8'd10;
      chk("R6", status[0], 1);
      clear_all(); step(3);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         bad++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule